// File: doc/BRIEF.md
# Four-Register ALU Datapath

This block is a small clocked datapath: a file of four 4-bit general-purpose registers feeding a combinational arithmetic/logic unit. Two independent read selects pick the first operand (A) and the second operand (B). A 4-bit opcode picks one of eleven operations. The result is shown on the `result` port in the same cycle. When write-back is enabled, the result is stored at the next rising clock edge into the register named by the write select.

Zero and carry status flags are captured in registers together with each write-back. They keep their values in every cycle without a write-back. A surrounding sequencer drives the selects, opcode and write enable directly, one operation per clock. The block has no fetch, no decode and no bus.

Top module: `quad_reg_alu`

## Requirements
- R1: With `rst` high at a rising edge, register i (i = 0..3) is loaded with the value i, and both flags are cleared. Reset is synchronous and active high.
- R2: `result` is a combinational function of the registers named by `sel_a` and `sel_b` and of `opcode`. The two selects are independent and may name the same register.
- R3: A register changes only at a rising edge with `wr_en` high. The register named by `wr_sel` then takes the value `result` had before that edge. All other registers, and every register when `wr_en` is low, keep their values.
- R4: Opcode 0000 gives A+B, with carry equal to bit 4 of the 5-bit sum. Opcode 0001 gives A-B modulo 16, with carry set when A < B.
- R5: Opcode 0010 gives the low 4 bits of A*B, with carry set when the upper 4 bits of the 8-bit product are not all zero.
- R6: Opcode 0011 gives A/B truncated, with carry clear. If B is 0, the result is 1111 and carry is set.
- R7: Opcodes 0100 AND, 0101 OR, 0110 XOR, 0111 XNOR and 1000 NOT A all give carry 0.
- R8: Opcode 1001 gives A shifted right by one, with carry equal to A bit 0. Opcode 1010 gives A shifted left by one, with carry equal to A bit 3.
- R9: Opcodes 1011 through 1111 give result 0000 and carry 0.
- R10: At a rising edge with `wr_en` high, `zero_flag` takes (result == 0) and `carry_flag` takes the operation's carry. With `wr_en` low, both flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_a | input | 2 | Register index of operand A |
| sel_b | input | 2 | Register index of operand B |
| wr_sel | input | 2 | Register index receiving the result |
| wr_en | input | 1 | Enables write-back and flag capture |
| opcode | input | 4 | Operation code |
| result | output | 4 | Combinational ALU result |
| zero_flag | output | 1 | Registered: last written result was zero |
| carry_flag | output | 1 | Registered: carry of last written operation |

## Verification
The clocked properties assume that the control inputs are settled, known values at each rising edge, and that reset is asserted for at least one edge before any checking matters. The bench meets this by changing every input only on falling edges. It holds reset across two edges, and draws selects, opcodes and write enables from $urandom with a fixed seed, so all sixteen opcodes are reached, including the five unused ones. Directed steps cover a divide by zero, multiply overflow, and the borrow and shift-out carries.

// File: rtl/quad_reg_alu_pkg.sv
package quad_reg_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_SUB  = 4'b0001,
    OP_MUL  = 4'b0010,
    OP_DIV  = 4'b0011,
    OP_AND  = 4'b0100,
    OP_OR   = 4'b0101,
    OP_XOR  = 4'b0110,
    OP_XNOR = 4'b0111,
    OP_NOT  = 4'b1000,
    OP_SHR  = 4'b1001,
    OP_SHL  = 4'b1010,
    OP_U11  = 4'b1011,
    OP_U12  = 4'b1100,
    OP_U13  = 4'b1101,
    OP_U14  = 4'b1110,
    OP_U15  = 4'b1111
  } alu_op_e;
endpackage

// File: rtl/qra_regfile.sv
module qra_regfile #(
  parameter int W    = 4,
  parameter int NREG = 4,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] rd_a,
  input  logic [SELW-1:0] rd_b,
  input  logic [SELW-1:0] wr_idx,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  output logic [W-1:0]    q_a,
  output logic [W-1:0]    q_b
);
  logic [NREG-1:0][W-1:0] mem;
  logic [NREG-1:0]        we_vec;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [W-1:0] INIT = W'(i);
    assign we_vec[i] = wr_en && (wr_idx == SELW'(i));
    always_ff @(posedge clk) begin
      if (rst)            mem[i] <= INIT;
      else if (we_vec[i]) mem[i] <= wr_data;
    end
    AST_RST_DEFAULT: assert property (@(posedge clk) rst |=> mem[i] == INIT); // R1
  end

  assign q_a = mem[rd_a];
  assign q_b = mem[rd_b];

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mem)); // R3
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_vec)); // R3
endmodule

// File: rtl/qra_alu.sv
module qra_alu
  import quad_reg_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         cy
);
  logic [W:0]     sum;
  logic [W:0]     dif;
  logic [2*W-1:0] prod;

  assign sum  = {1'b0, a} + {1'b0, b};
  assign dif  = {1'b0, a} - {1'b0, b};
  assign prod = (2*W)'(a) * (2*W)'(b);

  always_comb begin
    res = '0;
    cy  = 1'b0;
    unique case (op)
      OP_ADD:  begin res = sum[W-1:0]; cy = sum[W]; end
      OP_SUB:  begin res = dif[W-1:0]; cy = dif[W]; end
      OP_MUL:  begin res = prod[W-1:0]; cy = |prod[2*W-1:W]; end
      OP_DIV:  begin
        if (b == '0) begin res = '1; cy = 1'b1; end
        else         res = a / b;
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_XNOR: res = ~(a ^ b);
      OP_NOT:  res = ~a;
      OP_SHR:  begin res = a >> 1; cy = a[0]; end
      OP_SHL:  begin res = a << 1; cy = a[W-1]; end
      default: begin res = '0; cy = 1'b0; end
    endcase
  end
endmodule

// File: rtl/quad_reg_alu.sv
module quad_reg_alu
  import quad_reg_alu_pkg::*;
#(
  parameter int W    = 4,
  parameter int NREG = 4,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] sel_a,
  input  logic [SELW-1:0] sel_b,
  input  logic [SELW-1:0] wr_sel,
  input  logic            wr_en,
  input  logic [3:0]      opcode,
  output logic [W-1:0]    result,
  output logic            zero_flag,
  output logic            carry_flag
);
  logic [W-1:0] opa, opb, alu_res;
  logic         alu_cy;
  alu_op_e      op;

  assign op = alu_op_e'(opcode);

  qra_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .rd_a(sel_a), .rd_b(sel_b), .wr_idx(wr_sel),
    .wr_en(wr_en), .wr_data(alu_res), .q_a(opa), .q_b(opb)
  );

  qra_alu #(.W(W)) u_alu (
    .a(opa), .b(opb), .op(op), .res(alu_res), .cy(alu_cy)
  );

  assign result = alu_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_flag  <= 1'b0;
      carry_flag <= 1'b0;
    end else if (wr_en) begin
      zero_flag  <= (alu_res == '0);
      carry_flag <= alu_cy;
    end
  end

  AST_FLAGS_CLEAR: assert property (@(posedge clk) rst |=> !zero_flag && !carry_flag); // R1
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable({zero_flag, carry_flag})); // R10
  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> zero_flag == ($past(result) == '0)); // R10
  AST_DIV_BY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'b0011 && opb == '0) |-> (result == '1 && alu_cy)); // R6
  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (rst)
    (opcode > 4'b1010) |-> (result == '0 && !alu_cy)); // R9
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (opcode >= 4'b0100 && opcode <= 4'b1000 && wr_en) |=> !carry_flag); // R7
endmodule

// File: tb/tb_quad_reg_alu.sv
module tb_quad_reg_alu;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] sel_a, sel_b, wr_sel;
  logic       wr_en;
  logic [3:0] opcode;
  logic [3:0] result;
  logic       zero_flag, carry_flag;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model [4];
  logic       m_zero, m_carry;

  always #10 clk = ~clk;

  quad_reg_alu dut (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .wr_sel(wr_sel),
    .wr_en(wr_en), .opcode(opcode), .result(result),
    .zero_flag(zero_flag), .carry_flag(carry_flag)
  );

  function automatic logic [4:0] ref_op(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b);
    logic [7:0] p;
    case (op)
      4'd0: return {1'b0, a} + {1'b0, b};
      4'd1: return {(a < b), 4'(a - b)};
      4'd2: begin p = a * b; return {(p > 8'd15), p[3:0]}; end
      4'd3: return (b == 0) ? 5'b11111 : {1'b0, 4'(a / b)};
      4'd4: return {1'b0, a & b};
      4'd5: return {1'b0, a | b};
      4'd6: return {1'b0, a ^ b};
      4'd7: return {1'b0, ~(a ^ b)};
      4'd8: return {1'b0, ~a};
      4'd9: return {a[0], 1'b0, a[3:1]};
      4'd10: return {a[3], a[2:0], 1'b0};
      default: return 5'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 1) return "R4";
    if (op == 2) return "R5";
    if (op == 3) return "R6";
    if (op <= 8) return "R7";
    if (op <= 10) return "R8";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One operation: drive on falling edge, check result, clock, check flags.
  task automatic step(input logic [1:0] a, input logic [1:0] b, input logic [1:0] w,
                      input logic we, input logic [3:0] op);
    logic [4:0] e;
    @(negedge clk);
    sel_a = a; sel_b = b; wr_sel = w; wr_en = we; opcode = op;
    #2;
    e = ref_op(op, model[a], model[b]);
    check({tag_of(op), "/R2"}, {1'b0, result}, {1'b0, e[3:0]});
    if (we) begin
      model[w] = e[3:0];
      m_zero = (e[3:0] == 4'd0);
      m_carry = e[4];
    end
    @(posedge clk);
    #2;
    check({tag_of(op), "/R10"}, {3'b0, zero_flag, carry_flag}, {3'b0, m_zero, m_carry});
  endtask

  // Read register r out via A AND A without writing (R3 readback).
  task automatic peek(input logic [1:0] r, input string req);
    @(negedge clk);
    sel_a = r; sel_b = r; wr_en = 1'b0; opcode = 4'd4;
    #2;
    check(req, {1'b0, result}, {1'b0, model[r]});
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1'b1; sel_a = 0; sel_b = 0; wr_sel = 0; wr_en = 0; opcode = 0;
    repeat (2) @(posedge clk);
    #2;
    for (int i = 0; i < 4; i++) model[i] = 4'(i);
    m_zero = 0; m_carry = 0;
    check("R1 flags", {3'b0, zero_flag, carry_flag}, 5'b0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) peek(2'(i), "R1 default");

    // Directed corners.
    step(2'd3, 2'd0, 2'd1, 1'b1, 4'd3); // R6 divide by zero -> r1=F, carry
    step(2'd1, 2'd1, 2'd2, 1'b1, 4'd2); // R5 F*F overflow
    step(2'd0, 2'd3, 2'd0, 1'b1, 4'd1); // R4 borrow 0-3
    step(2'd1, 2'd3, 2'd3, 1'b1, 4'd0); // R4 F+3 carry out
    step(2'd1, 2'd1, 2'd2, 1'b1, 4'd10); // R8 shl carry out
    step(2'd3, 2'd3, 2'd2, 1'b1, 4'd9); // R8 shr of 2
    step(2'd1, 2'd1, 2'd0, 1'b1, 4'd6); // R10 zero result
    step(2'd1, 2'd2, 2'd3, 1'b0, 4'd2); // R3 no write, flags hold
    for (int i = 0; i < 4; i++) peek(2'(i), "R3 hold");
    step(2'd2, 2'd1, 2'd0, 1'b1, 4'd13); // R9 unused opcode

    for (int n = 0; n < 400; n++) begin
      step(2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 4'($urandom));
      if (n % 50 == 0)
        for (int i = 0; i < 4; i++) peek(2'(i), "R3 contents");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule